// File: doc/BRIEF.md
# Program Counter and Fetch Sequencer

This block owns the program counter of a small processor and presents, on every cycle, the word address that the instruction memory should read. It starts fetching on its own once reset is released: the first address is zero, and each cycle the address then moves forward by one word. The decode stage feeds back the opcode it is looking at, qualified by a valid strobe, along with the immediate-select bit, a register operand, an immediate field and the zero and carry flags.

Three redirect opcodes load a new address in place of the increment. One is unconditional, one fires only on the zero flag, and one fires only on the carry flag. Each redirect takes its target from the register operand when the immediate-select bit is low, and from the immediate field when it is high. A redirect whose flag is clear falls through to the next word. A halt opcode freezes the address and drops the fetch strobe permanently. Only a synchronous reset brings the block back.

Top module: `fetch_sequencer`

## Requirements
- R1: In the cycle after synchronous reset (`rst` high at a rising edge), `fetch_addr` is 0, `fetch_valid` is 1 and `halted` is 0, with no other input needed to begin fetching.
- R2: While not halted, a cycle with `dec_valid` low, or with a valid opcode other than 4'b0000, 4'b0100, 4'b0101 and 4'b0110, makes `fetch_addr` one greater on the next cycle.
- R3: While not halted, a valid opcode 4'b0100 loads `fetch_addr` on the next cycle with `reg_target` when `imm_sel` is 0, or with `imm_value` when `imm_sel` is 1.
- R4: While not halted, a valid opcode 4'b0101 loads the target chosen as in R3 when `flag_z` is 1. When `flag_z` is 0 it advances by one. `flag_c` has no effect on it.
- R5: While not halted, a valid opcode 4'b0110 loads the target chosen as in R3 when `flag_c` is 1. When `flag_c` is 0 it advances by one. `flag_z` has no effect on it.
- R6: A valid opcode 4'b0000, with either value of `imm_sel`, makes `halted` 1 and `fetch_valid` 0 from the next cycle on. `fetch_addr` is held, and every later input is ignored until reset.
- R7: Advancing from the all-ones address wraps `fetch_addr` to 0.
- R8: A reset applied while halted resumes fetching from address 0 as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode stage holds a real instruction this cycle |
| dec_opcode | input | 4 | Opcode of the instruction being decoded |
| imm_sel | input | 1 | 1 selects the immediate target, 0 the register target |
| reg_target | input | ADDR_W (16) | Register operand value used as jump target |
| imm_value | input | ADDR_W (16) | Immediate field used as jump target |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| fetch_addr | output | ADDR_W (16) | Word address presented to instruction memory |
| fetch_valid | output | 1 | Fetch request strobe, low once halted |
| halted | output | 1 | Sticky halt status |

## Verification
The bench builds the block with its default 16-bit address width, so that register and immediate targets are full memory addresses. At that width a jump to 16'hFFFE reaches the wrap from all-ones back to zero within two plain steps. Every redirect opcode is driven in both target forms and with each flag value, including the off-flag, and the bench checks that the off-flag is ignored. The halt opcode is driven in both immediate-select forms and is followed by jump traffic, which must leave the frozen address untouched until reset.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_HALT  = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_JZERO = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_JCARR = 4'b0110;

    typedef enum logic [1:0] {
        ACT_STEP = 2'd0,
        ACT_JUMP = 2'd1,
        ACT_HALT = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        COND_NONE  = 2'd0,
        COND_ZERO  = 2'd1,
        COND_CARRY = 2'd2
    } cond_e;

    typedef struct packed {
        act_e  act;
        cond_e cond;
        logic  use_imm;
    } ctl_t;

    function automatic ctl_t classify(input logic vld,
                                      input logic [OPC_W-1:0] opc,
                                      input logic imm);
        ctl_t c;
        c.act     = ACT_STEP;
        c.cond    = COND_NONE;
        c.use_imm = imm;
        if (vld) begin
            case (opc)
                OPC_HALT:  c.act = ACT_HALT;
                OPC_JUMP:  c.act = ACT_JUMP;
                OPC_JZERO: begin c.act = ACT_JUMP; c.cond = COND_ZERO;  end
                OPC_JCARR: begin c.act = ACT_JUMP; c.cond = COND_CARRY; end
                default:   c.act = ACT_STEP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
    import fseq_pkg::*;
(
    input  logic             dec_valid,
    input  logic [OPC_W-1:0] dec_opcode,
    input  logic             imm_sel,
    input  logic             flag_z,
    input  logic             flag_c,
    output ctl_t             ctl,
    output logic             take_jump
);
    logic cond_ok;

    always_comb begin
        ctl = classify(dec_valid, dec_opcode, imm_sel);
        case (ctl.cond)
            COND_ZERO:  cond_ok = flag_z;
            COND_CARRY: cond_ok = flag_c;
            default:    cond_ok = 1'b1;
        endcase
        take_jump = (ctl.act == ACT_JUMP) && cond_ok;
    end
endmodule

// File: rtl/fseq_next.sv
module fseq_next
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [ADDR_W-1:0] reg_target,
    input  logic [ADDR_W-1:0] imm_value,
    input  ctl_t              ctl,
    input  logic              take_jump,
    output logic [ADDR_W-1:0] pc_next
);
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] seq_addr;

    always_comb begin
        target   = ctl.use_imm ? imm_value : reg_target;
        seq_addr = pc_now + {{(ADDR_W-1){1'b0}}, 1'b1};
        pc_next  = take_jump ? target : seq_addr;
    end
endmodule

// File: rtl/fseq_state.sv
module fseq_state
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] pc_next,
    output logic [ADDR_W-1:0] pc_q,
    output logic              halt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            halt_q <= 1'b0;
        end else if (!halt_q) begin
            if (ctl.act == ACT_HALT) begin
                halt_q <= 1'b1;
            end else begin
                pc_q <= pc_next;
            end
        end
    end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [3:0]        dec_opcode,
    input  logic              imm_sel,
    input  logic [ADDR_W-1:0] reg_target,
    input  logic [ADDR_W-1:0] imm_value,
    input  logic              flag_z,
    input  logic              flag_c,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid,
    output logic              halted
);
    ctl_t              ctl;
    logic              take_jump;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_next;
    logic              halt_q;

    fseq_decode u_decode (
        .dec_valid (dec_valid),
        .dec_opcode(dec_opcode),
        .imm_sel   (imm_sel),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .ctl       (ctl),
        .take_jump (take_jump)
    );

    fseq_next #(.ADDR_W(ADDR_W)) u_next (
        .pc_now    (pc_q),
        .reg_target(reg_target),
        .imm_value (imm_value),
        .ctl       (ctl),
        .take_jump (take_jump),
        .pc_next   (pc_next)
    );

    fseq_state #(.ADDR_W(ADDR_W)) u_state (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .pc_next(pc_next),
        .pc_q   (pc_q),
        .halt_q (halt_q)
    );

    assign fetch_addr  = pc_q;
    assign fetch_valid = !halt_q;
    assign halted      = halt_q;
endmodule

// File: rtl/fetch_sequencer_chk.sv
module fetch_sequencer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dec_valid,
    input logic [3:0]        dec_opcode,
    input logic              imm_sel,
    input logic [ADDR_W-1:0] reg_target,
    input logic [ADDR_W-1:0] imm_value,
    input logic              flag_z,
    input logic              flag_c,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_valid,
    input logic              halted
);
    logic live;
    assign live = !halted && fetch_valid;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (fetch_addr == '0 && fetch_valid && !halted));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (live && !dec_valid) |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)));

    // R3
    jump_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (live && dec_valid && dec_opcode == 4'b0100 && !imm_sel)
        |=> (fetch_addr == $past(reg_target)));

    // R4
    jz_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (live && dec_valid && dec_opcode == 4'b0101 && !flag_z)
        |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)));

    // R5
    jc_imm_chk: assert property (@(posedge clk) disable iff (rst)
        (live && dec_valid && dec_opcode == 4'b0110 && flag_c && imm_sel)
        |=> (fetch_addr == $past(imm_value)));

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !fetch_valid && $stable(fetch_addr)));

    // R6
    halt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> $past(dec_valid && dec_opcode == 4'b0000));
endmodule

bind fetch_sequencer fetch_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dec_valid  (dec_valid),
    .dec_opcode (dec_opcode),
    .imm_sel    (imm_sel),
    .reg_target (reg_target),
    .imm_value  (imm_value),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .fetch_addr (fetch_addr),
    .fetch_valid(fetch_valid),
    .halted     (halted)
);

// File: tb/fetch_sequencer_test.sv
`timescale 1ns/1ps
module fetch_sequencer_test;
    localparam int ADDR_W = 16;
    localparam int MASK   = (1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dec_valid = 1'b0;
    logic [3:0]        dec_opcode = 4'b0111;
    logic              imm_sel = 1'b0;
    logic [ADDR_W-1:0] reg_target = '0;
    logic [ADDR_W-1:0] imm_value = '0;
    logic              flag_z = 1'b0;
    logic              flag_c = 1'b0;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_valid;
    logic              halted;

    int compared   = 0;
    int mismatched = 0;
    int m_pc       = 0;
    bit m_halt     = 1'b0;

    always #4 clk = ~clk;

    fetch_sequencer #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_opcode(dec_opcode),
        .imm_sel(imm_sel), .reg_target(reg_target), .imm_value(imm_value),
        .flag_z(flag_z), .flag_c(flag_c), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .halted(halted)
    );

    task automatic compare(input string req);
        compared++;
        if (fetch_addr !== m_pc[ADDR_W-1:0] || fetch_valid !== !m_halt || halted !== m_halt) begin
            mismatched++;
            $display("FAIL %s: addr=%h valid=%b halted=%b expected addr=%h valid=%b halted=%b",
                     req, fetch_addr, fetch_valid, halted, m_pc[ADDR_W-1:0], !m_halt, m_halt);
        end
    endtask

    // one clock: apply inputs, advance the model, compare away from the edge
    task automatic cyc(input bit r, input bit v, input logic [3:0] op, input bit imm,
                       input int rt, input int iv, input bit z, input bit c,
                       input string req);
        bit jmp;
        bit cond;
        rst = r; dec_valid = v; dec_opcode = op; imm_sel = imm;
        reg_target = rt[ADDR_W-1:0]; imm_value = iv[ADDR_W-1:0];
        flag_z = z; flag_c = c;
        @(posedge clk);
        if (r) begin
            m_pc = 0; m_halt = 1'b0;
        end else if (!m_halt) begin
            jmp = 1'b0;
            cond = 1'b0;
            if (v && op == 4'd0)       m_halt = 1'b1;
            else if (v && op == 4'd4) begin jmp = 1'b1; cond = 1'b1; end
            else if (v && op == 4'd5) begin jmp = 1'b1; cond = z; end
            else if (v && op == 4'd6) begin jmp = 1'b1; cond = c; end
            if (!m_halt) begin
                if (jmp && cond) m_pc = imm ? iv : rt;
                else             m_pc = m_pc + 1;
                m_pc = m_pc & MASK;
            end
        end
        #2;
        compare(req);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(0, 0, 4'd7, 0, 0, 0, 0, 0, req);
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL watchdog: expired, expected run to finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(1, 0, 4'd7, 0, 0, 0, 0, 0, "R1");
        cyc(1, 1, 4'd0, 0, 0, 0, 0, 0, "R1");
        idle(5, "R1 R2 autostart");
        // R2: non-redirect opcodes and an unqualified halt code
        cyc(0, 1, 4'd7, 0, 16'h1111, 16'h2222, 1, 1, "R2 nop");
        cyc(0, 1, 4'd8, 1, 16'h1111, 16'h2222, 1, 1, "R2 add");
        cyc(0, 1, 4'd15, 0, 16'h1111, 16'h2222, 1, 1, "R2 cmp");
        cyc(0, 0, 4'd0, 0, 16'h1111, 16'h2222, 0, 0, "R2 halt code not valid");
        cyc(0, 0, 4'd4, 0, 16'h1111, 16'h2222, 1, 1, "R2 jump code not valid");
        // R3
        cyc(0, 1, 4'd4, 0, 16'h1234, 16'h9999, 0, 0, "R3 reg");
        idle(2, "R2");
        cyc(0, 1, 4'd4, 1, 16'h9999, 16'h00AB, 0, 0, "R3 imm");
        // R4
        cyc(0, 1, 4'd5, 0, 16'h0400, 16'h0500, 1, 0, "R4 reg taken");
        cyc(0, 1, 4'd5, 1, 16'h0400, 16'h0500, 0, 0, "R4 imm not taken");
        cyc(0, 1, 4'd5, 0, 16'h0400, 16'h0500, 0, 1, "R4 carry ignored");
        cyc(0, 1, 4'd5, 1, 16'h0400, 16'h0500, 1, 1, "R4 imm taken");
        // R5
        cyc(0, 1, 4'd6, 0, 16'h0A00, 16'h0B00, 0, 1, "R5 reg taken");
        cyc(0, 1, 4'd6, 0, 16'h0A00, 16'h0B00, 0, 0, "R5 not taken");
        cyc(0, 1, 4'd6, 1, 16'h0A00, 16'h0B00, 1, 0, "R5 zero ignored");
        cyc(0, 1, 4'd6, 1, 16'h0A00, 16'h0B00, 0, 1, "R5 imm taken");
        // back-to-back redirects
        cyc(0, 1, 4'd4, 1, 0, 16'h0010, 0, 0, "R3 chain");
        cyc(0, 1, 4'd4, 0, 16'h0020, 0, 0, 0, "R3 chain");
        // R7 wrap
        cyc(0, 1, 4'd4, 1, 0, 16'hFFFE, 0, 0, "R7 setup");
        idle(3, "R7 wrap");
        // R6 halt, then inputs must be ignored
        cyc(0, 1, 4'd0, 0, 16'h4444, 16'h5555, 1, 1, "R6 halt");
        cyc(0, 1, 4'd4, 0, 16'h4444, 16'h5555, 1, 1, "R6 jump ignored");
        cyc(0, 1, 4'd5, 1, 16'h4444, 16'h5555, 1, 1, "R6 jz ignored");
        idle(4, "R6 frozen");
        // R8
        cyc(1, 0, 4'd7, 0, 0, 0, 0, 0, "R8 reset");
        idle(3, "R8 resume");
        // R6 halt with immediate bit set
        cyc(0, 1, 4'd0, 1, 16'h7777, 16'h7777, 0, 0, "R6 halt imm form");
        cyc(0, 1, 4'd6, 1, 16'h7777, 16'h7777, 0, 1, "R6 jc ignored");
        idle(2, "R6 frozen");
        cyc(1, 0, 4'd7, 0, 0, 0, 0, 0, "R8 reset");
        cyc(0, 1, 4'd4, 0, 16'hFFFF, 0, 0, 0, "R7 setup");
        idle(2, "R7 wrap from all-ones");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule